// File: doc/BRIEF.md
# Coprime Ring Coincidence Delay Timer

This block produces a periodic one-cycle tick over a long interval. It does not use a wide binary counter for this. Two short circular shift registers each carry a single set bit. Both rotate one stage on every enabled clock. Their lengths share no common factor, so both set bits reach their final stages together only once every `LEN_A * LEN_B` enabled clocks. The tick is raised in that cycle. With the default lengths of 15 and 16, the period is 240 enabled clocks, and the whole state is 31 flops.

The control pins are plain level inputs; the block has no data path and no handshake. A synchronous restart puts each ring's set bit back on its first stage. The enable pauses the rings without losing their place. The ring lengths are parameters, each from 2 to 16. Elaboration stops with an error if a length is out of range or if the two lengths have a common factor.

Top module: `coprime_tick_timer`

## Requirements
- R1: In a cycle with `restart` high, at the clock edge each ring is loaded with its set bit on its first stage (bit 0). Counting the later cycles with `en` high and `restart` low as 1, 2, 3 and so on, the first tick is high in cycle number `LEN_A*LEN_B`, which is 240 with the defaults, and in no earlier cycle.
- R2: Once a restart has happened, each ring holds exactly one set bit at every clock edge.
- R3: Once the first tick has occurred, successive ticks are exactly `LEN_A*LEN_B` enabled, non-restart cycles apart. A tick is high in exactly those cycles.
- R4: While `en` is low, both rings keep their contents and `tick` stays low. The cycles spent paused are added to the tick interval. A tick that was due in a paused cycle appears in the next enabled cycle instead.
- R5: `tick` is high for a single cycle at a time. It is never high in two consecutive cycles.
- R6: `restart` overrides `en`: `tick` is low in any cycle where `restart` is high, including a cycle in which a tick was otherwise due.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| restart | input | 1 | Synchronous restart: both set bits return to their first stage |
| en | input | 1 | Advance both rings by one stage at this edge; tick is gated off while low |
| tick | output | 1 | One-cycle pulse when both rings sit on their final stage |

## Verification
The assertions assume that `restart` is applied at least once before the ring contents mean anything. They stay disabled until the first restart has been seen, because the rings are undefined before that. They also assume that `en` and `restart` are driven to known levels at every edge. The stimulus applies a restart first and changes both inputs only at falling edges. Pauses, a restart in the middle of a run, and a restart in the very cycle a tick is due are all placed after that first restart.

// File: rtl/coprime_tick_pkg.sv
package coprime_tick_pkg;

  localparam int unsigned RING_MIN_LEN = 2;
  localparam int unsigned RING_MAX_LEN = 16;

  // Greatest common divisor by repeated remainder; bounded loop so it
  // stays a constant function usable at elaboration.
  function automatic int unsigned gcd_of(input int unsigned a, input int unsigned b);
    int unsigned x;
    int unsigned y;
    int unsigned t;
    x = a;
    y = b;
    for (int i = 0; i < 32; i++) begin
      if (y != 0) begin
        t = x % y;
        x = y;
        y = t;
      end
    end
    return x;
  endfunction

  function automatic bit lengths_ok(input int unsigned a, input int unsigned b);
    return (a >= RING_MIN_LEN) && (a <= RING_MAX_LEN) &&
           (b >= RING_MIN_LEN) && (b <= RING_MAX_LEN) &&
           (gcd_of(a, b) == 1);
  endfunction

endpackage

// File: rtl/onehot_ring.sv
module onehot_ring #(
  parameter int unsigned LEN = 15
) (
  input  logic           clk,
  input  logic           restart,
  input  logic           en,
  output logic [LEN-1:0] state,
  output logic           tap
);

  localparam logic [LEN-1:0] SEED = LEN'(1);

  logic [LEN-1:0] ring_q;

  // Set bit moves from stage i to stage i+1; last stage wraps to stage 0.
  always_ff @(posedge clk) begin
    if (restart) begin
      ring_q <= SEED;
    end else if (en) begin
      ring_q <= {ring_q[LEN-2:0], ring_q[LEN-1]};
    end
  end

  assign state = ring_q;
  assign tap   = ring_q[LEN-1];

endmodule

// File: rtl/tick_gate.sv
module tick_gate (
  input  logic restart,
  input  logic en,
  input  logic tap_a,
  input  logic tap_b,
  output logic tick
);

  // Both rings on their last stage means the coming edge returns both to
  // stage 0 together: this is the one cycle of the period to flag.
  always_comb begin
    tick = en & ~restart & tap_a & tap_b;
  end

endmodule

// File: rtl/coprime_tick_timer.sv
module coprime_tick_timer #(
  parameter int unsigned LEN_A = 15,
  parameter int unsigned LEN_B = 16
) (
  input  logic clk,
  input  logic restart,
  input  logic en,
  output logic tick
);

  import coprime_tick_pkg::*;

  localparam bit PARAMS_OK = lengths_ok(LEN_A, LEN_B);

  generate
    if (!PARAMS_OK) begin : g_bad_lengths
      $error("ring lengths must each be 2..16 and share no common factor");
    end
  endgenerate

  logic [LEN_A-1:0] ring_a_q;
  logic [LEN_B-1:0] ring_b_q;
  logic             tap_a;
  logic             tap_b;

  onehot_ring #(.LEN(LEN_A)) u_ring_a (
    .clk     (clk),
    .restart (restart),
    .en      (en),
    .state   (ring_a_q),
    .tap     (tap_a)
  );

  onehot_ring #(.LEN(LEN_B)) u_ring_b (
    .clk     (clk),
    .restart (restart),
    .en      (en),
    .state   (ring_b_q),
    .tap     (tap_b)
  );

  tick_gate u_gate (
    .restart (restart),
    .en      (en),
    .tap_a   (tap_a),
    .tap_b   (tap_b),
    .tick    (tick)
  );

endmodule

// File: rtl/coprime_tick_timer_chk.sv
module coprime_tick_timer_chk #(
  parameter int unsigned LEN_A = 15,
  parameter int unsigned LEN_B = 16
) (
  input logic             clk,
  input logic             restart,
  input logic             en,
  input logic             tick,
  input logic [LEN_A-1:0] ring_a,
  input logic [LEN_B-1:0] ring_b
);

  localparam int unsigned PERIOD = LEN_A * LEN_B;
  localparam int unsigned CW     = $clog2(PERIOD) + 1;

  logic          armed = 1'b0;
  logic [CW-1:0] phase = '0;

  // Independent position count within the period, for window checks.
  always_ff @(posedge clk) begin
    if (restart) begin
      armed <= 1'b1;
      phase <= '0;
    end else if (en) begin
      phase <= (phase == CW'(PERIOD - 1)) ? '0 : phase + 1'b1;
    end
  end

  assert_restart_seed_R1: assert property (@(posedge clk)
    restart |=> (ring_a == LEN_A'(1)) && (ring_b == LEN_B'(1)));

  assert_onehot_a_R2: assert property (@(posedge clk) disable iff (!armed)
    $countones(ring_a) == 1);

  assert_onehot_b_R2: assert property (@(posedge clk) disable iff (!armed)
    $countones(ring_b) == 1);

  assert_tick_in_window_R3: assert property (@(posedge clk) disable iff (!armed)
    tick |-> (phase == CW'(PERIOD - 1)));

  assert_window_ticks_R3: assert property (@(posedge clk) disable iff (!armed)
    (en && !restart && phase == CW'(PERIOD - 1)) |-> tick);

  assert_tick_rewinds_R3: assert property (@(posedge clk) disable iff (!armed)
    tick |=> (ring_a == LEN_A'(1)) && (ring_b == LEN_B'(1)));

  assert_pause_holds_R4: assert property (@(posedge clk) disable iff (!armed)
    (!en && !restart) |=> $stable(ring_a) && $stable(ring_b));

  assert_pause_quiet_R4: assert property (@(posedge clk) disable iff (!armed)
    !en |-> !tick);

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!armed || restart)
    tick |=> !tick);

  assert_restart_quiet_R6: assert property (@(posedge clk) disable iff (!armed)
    restart |-> !tick);

endmodule

bind coprime_tick_timer coprime_tick_timer_chk #(
  .LEN_A (LEN_A),
  .LEN_B (LEN_B)
) u_chk (
  .clk     (clk),
  .restart (restart),
  .en      (en),
  .tick    (tick),
  .ring_a  (ring_a_q),
  .ring_b  (ring_b_q)
);

// File: tb/coprime_tick_timer_tb.sv
`timescale 1ns/1ps
module coprime_tick_timer_tb;

  localparam int unsigned LEN_A  = 15;
  localparam int unsigned LEN_B  = 16;
  localparam int          PERIOD = LEN_A * LEN_B;

  logic clk = 1'b0;
  logic restart = 1'b0;
  logic en = 1'b0;
  logic tick;

  int checks = 0;
  int errors = 0;
  int pos = 0;
  bit pos_valid = 1'b0;
  bit prev_tick = 1'b0;

  always #4 clk = ~clk;

  coprime_tick_timer #(.LEN_A(LEN_A), .LEN_B(LEN_B)) u_dut (
    .clk     (clk),
    .restart (restart),
    .en      (en),
    .tick    (tick)
  );

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b (pos %0d)", tag, what, act, exp, pos);
    end
  endtask

  // One cycle: drive at falling edge, sample before the rising edge,
  // then advance the expected position.
  task automatic step(input logic e, input logic r, input string tag, output logic seen);
    logic exp;
    @(negedge clk);
    en = e;
    restart = r;
    #1;
    exp = e && !r && pos_valid && (pos == PERIOD - 1);
    check(tick, exp, tag, "tick level");
    if (pos_valid && prev_tick) check(tick, 1'b0, "R5", "pulse width");
    seen = tick;
    prev_tick = tick;
    @(posedge clk);
    if (r) begin
      pos = 0;
      pos_valid = 1'b1;
    end else if (e && pos_valid) begin
      pos = (pos + 1) % PERIOD;
    end
  endtask

  task automatic t_restart_first_tick();
    logic s;
    int first = -1;
    step(1'b0, 1'b1, "R6", s);
    check(s, 1'b0, "R1", "tick during restart");
    for (int i = 1; i <= PERIOD + 2; i++) begin
      step(1'b1, 1'b0, "R1", s);
      if (s && first < 0) first = i;
    end
    checks++;
    if (first != PERIOD) begin
      errors++;
      $display("FAIL R1 first tick cycle: actual %0d expected %0d", first, PERIOD);
    end
  endtask

  task automatic t_spacing();
    logic s;
    int last = -1;
    int seen_n = 0;
    for (int i = 0; i < 3 * PERIOD + 5; i++) begin
      step(1'b1, 1'b0, "R3", s);
      if (s) begin
        if (last >= 0) begin
          checks++;
          if (i - last != PERIOD) begin
            errors++;
            $display("FAIL R3 tick spacing: actual %0d expected %0d", i - last, PERIOD);
          end
        end
        last = i;
        seen_n++;
      end
    end
    checks++;
    if (seen_n != 3) begin
      errors++;
      $display("FAIL R3 tick count over three periods: actual %0d expected 3", seen_n);
    end
  endtask

  task automatic t_pause();
    logic s;
    for (int i = 0; i < 100; i++) step(1'b1, 1'b0, "R4", s);
    for (int i = 0; i < 40; i++) step(1'b0, 1'b0, "R4", s);
    // Park exactly on the due cycle, then pause across it.
    while (pos != PERIOD - 1) step(1'b1, 1'b0, "R4", s);
    for (int i = 0; i < 5; i++) begin
      step(1'b0, 1'b0, "R4", s);
      check(s, 1'b0, "R4", "tick while paused");
    end
    step(1'b1, 1'b0, "R4", s);
    check(s, 1'b1, "R4", "deferred tick after pause");
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, "R4", s);
  endtask

  task automatic t_restart_mid();
    logic s;
    for (int i = 0; i < 50; i++) step(1'b1, 1'b0, "R6", s);
    step(1'b1, 1'b1, "R6", s);
    for (int i = 0; i < PERIOD; i++) step(1'b1, 1'b0, "R6", s);
    // Restart in the very cycle a tick is due.
    while (pos != PERIOD - 1) step(1'b1, 1'b0, "R6", s);
    step(1'b1, 1'b1, "R6", s);
    check(s, 1'b0, "R6", "restart masks due tick");
    for (int i = 0; i < PERIOD; i++) step(1'b1, 1'b0, "R6", s);
  endtask

  initial begin
    t_restart_first_tick();
    t_spacing();
    t_pause();
    t_restart_mid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule